// File: doc/BRIEF.md
# Lap and Split Recall Memory

This block keeps the most recent timing records captured by a chronograph so that a user can review them later. Each record carries a record number, an interval time and a cumulative time. A record write adds one record. When the buffer is already full, the oldest record is silently dropped to make room. One trailing stop entry holds the interval and total at the moment counting stopped, and it is listed after the newest record.

The memory holds only one kind of data at a time, either lap data or split data. It is tagged with that kind. Changing the kind, or pulsing the clear input, empties it. In lap mode the block tracks the fastest lap. The best flag is tied to the stored entry itself, not to its wrapping number, so an unrelated entry that later reuses the same number is never flagged. A held best button peeks at the best lap, and releasing it returns to the entry that was being viewed.

Review starts with an enter pulse that always selects the oldest stored record. Next and previous pulses then step through the records, and the selected entry's fields appear on the outputs in the same cycle as the state update.

Top module: `recall_memory`

## Requirements
- R1: The buffer retains at most DEPTH (10) records. A record write into a full buffer discards the oldest record, and the remaining records keep their write order.
- R2: `outKind` shows the kind of data held (0 = lap, 1 = split). A change of `modeTag` empties the memory and sets the kind to the new value.
- R3: A `clearAll` pulse empties the memory, so `outValid` reads 0 in the following cycle.
- R4: A stop write creates one stop entry that is placed after the newest record. The stop entry shows `outIsStop` = 1 and `outNum` as all ones (the dashes code). A later record write removes it, and a later stop write replaces it.
- R5: An `enterRecall` pulse selects the oldest stored record and ends any best view, whatever position was selected before.
- R6: A `btnNext` pulse moves one entry toward the newest and a `btnPrev` pulse moves one entry toward the oldest. Both stop at the oldest record and at the last entry (the stop entry if one exists) without wrapping. Pulsing both in the same cycle has no effect.
- R7: While `btnBest` is held in lap mode, the outputs show the best lap's number, interval and total with `outIsBest` = 1. Releasing `btnBest` restores the previous entry. A next or previous pulse during the hold also restores that entry without moving, and the best view does not return until `btnBest` has been released and pressed again.
- R8: In lap mode the best lap is the record with the strictly smallest interval. On a tie the earlier record stays best. Split data never has a best entry, and a held `btnBest` has no effect on it.
- R9: `outIsBest` lights for a stored record only if that record is the best entry itself. A newer record that carries the same number as an evicted best entry is not flagged, and the best view still shows the evicted best values.
- R10: For lap data `outTotal` is the selected record's own cumulative time. For split data it is the final total: the stop total if a stop entry exists, otherwise the newest record's total.
- R11: With the memory empty, `outValid` is 0, all fields read 0, and navigation pulses leave it empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| recWr | input | 1 | Record write strobe |
| recNum | input | NUM_W | Number of the written record |
| recInterval | input | TIME_W | Interval time of the written record |
| recTotal | input | TIME_W | Cumulative time of the written record |
| stopWr | input | 1 | Stop entry write strobe |
| stopInterval | input | TIME_W | Interval at the stop point |
| stopTotal | input | TIME_W | Total at the stop point |
| clearAll | input | 1 | Empties the memory |
| modeTag | input | 1 | Data kind: 0 lap, 1 split |
| btnNext | input | 1 | Step-to-next pulse |
| btnPrev | input | 1 | Step-to-previous pulse |
| btnBest | input | 1 | Best view hold level |
| enterRecall | input | 1 | Start review at the oldest record |
| outValid | output | 1 | An entry is shown |
| outNum | output | NUM_W | Shown number, all ones for the stop entry |
| outInterval | output | TIME_W | Shown interval |
| outTotal | output | TIME_W | Shown cumulative or final total |
| outIsStop | output | 1 | Stop entry shown |
| outIsBest | output | 1 | Best entry shown |
| outKind | output | 1 | Kind of data held |

## Verification
The assertions assume that `btnNext`, `btnPrev`, `enterRecall`, `recWr`, `stopWr` and `clearAll` are single-cycle pulses, that `btnBest` is a level, and that record and stop strobes do not arrive in the same cycle. They also assume that the writer supplies totals that never decrease within one run. The directed stimulus drives every strobe for exactly one cycle on the falling edge, keeps writes and navigation in separate cycles, and changes `modeTag` only between scenarios. The properties on best-interval monotonicity and position range therefore hold across all of the scenarios.

// File: rtl/recall_pkg.sv
package recall_pkg;

  typedef enum logic {
    KIND_LAP   = 1'b0,
    KIND_SPLIT = 1'b1
  } recKind_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clr;       // wipe contents
    logic wrRec;     // store record into wrSlot
    logic evict;     // the write overwrites the oldest slot
    logic wrStop;    // store stop entry
    logic viewValid; // something is shown
    logic viewStop;  // stop entry is selected
    logic viewBest;  // best peek active
  } ctlStrobes_t;

endpackage

// File: rtl/recall_control.sv
module recall_control
  import recall_pkg::*;
#(
  parameter int DEPTH  = 10,
  parameter int SLOT_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              recWr,
  input  logic              stopWr,
  input  logic              clearAll,
  input  logic              modeTag,
  input  logic              btnNext,
  input  logic              btnPrev,
  input  logic              btnBest,
  input  logic              enterRecall,
  input  logic              bestAvail,
  output ctlStrobes_t       strobes,
  output logic [SLOT_W-1:0] wrSlot,
  output logic [SLOT_W-1:0] viewSlot,
  output recKind_t          kind
);

  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int SUM_W = CNT_W + 1;
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);
  localparam logic [SUM_W-1:0] DEPTH_S = SUM_W'(DEPTH);

  logic [SLOT_W-1:0] headQ;
  logic [CNT_W-1:0]  countQ;
  logic [CNT_W-1:0]  posQ;
  logic              stopQ;
  logic              bestViewQ;
  logic              bestPrevQ;
  recKind_t          kindQ;

  logic              clr;
  logic              full;
  logic              nonEmpty;
  logic [CNT_W-1:0]  lastIdx;
  logic [CNT_W-1:0]  posNext;
  logic              bestViewNext;
  logic              navOne;

  function automatic logic [SLOT_W-1:0] wrapAdd(input logic [SLOT_W-1:0] base,
                                                input logic [CNT_W-1:0] off);
    logic [SUM_W-1:0] sum;
    sum = SUM_W'(base) + SUM_W'(off);
    if (sum >= DEPTH_S) sum = sum - DEPTH_S;
    return SLOT_W'(sum);
  endfunction

  assign clr      = clearAll | (modeTag != logic'(kindQ));
  assign full     = (countQ == DEPTH_C);
  assign nonEmpty = (countQ != '0) | stopQ;
  assign lastIdx  = countQ + CNT_W'(stopQ) - CNT_W'(1);
  assign navOne   = btnNext ^ btnPrev;

  assign wrSlot   = full ? headQ : wrapAdd(headQ, countQ);
  assign viewSlot = wrapAdd(headQ, posQ);
  assign kind     = kindQ;

  always_comb begin
    strobes.clr       = clr;
    strobes.wrRec     = recWr & ~clr;
    strobes.evict     = recWr & ~clr & full;
    strobes.wrStop    = stopWr & ~clr;
    strobes.viewValid = nonEmpty;
    strobes.viewStop  = stopQ & (posQ == countQ);
    strobes.viewBest  = bestViewQ;
  end

  // best peek state
  always_comb begin
    if (enterRecall || !btnBest || btnNext || btnPrev)
      bestViewNext = 1'b0;
    else
      bestViewNext = bestViewQ | (~bestPrevQ & bestAvail & nonEmpty);
  end

  // navigation position
  always_comb begin
    posNext = posQ;
    if (enterRecall) begin
      posNext = '0;
    end else if (!bestViewQ && nonEmpty && navOne) begin
      if (btnNext && posQ < lastIdx) posNext = posQ + CNT_W'(1);
      if (btnPrev && posQ != '0)     posNext = posQ - CNT_W'(1);
    end
    // a full write drops the stop entry, keep the position on a record
    if (recWr && full && posNext == DEPTH_C) posNext = DEPTH_C - CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      headQ     <= '0;
      countQ    <= '0;
      posQ      <= '0;
      stopQ     <= 1'b0;
      bestViewQ <= 1'b0;
      bestPrevQ <= 1'b0;
      kindQ     <= KIND_LAP;
    end else begin
      bestPrevQ <= btnBest;
      kindQ     <= recKind_t'(modeTag);
      if (clr) begin
        headQ     <= '0;
        countQ    <= '0;
        posQ      <= '0;
        stopQ     <= 1'b0;
        bestViewQ <= 1'b0;
      end else begin
        posQ      <= posNext;
        bestViewQ <= bestViewNext;
        if (recWr) begin
          stopQ <= 1'b0;
          if (full) headQ <= wrapAdd(headQ, CNT_W'(1));
          else      countQ <= countQ + CNT_W'(1);
        end
        if (stopWr) stopQ <= 1'b1;
      end
    end
  end

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    countQ <= DEPTH_C); // R1

  AST_HEAD_HOLD_FILL: assert property (@(posedge clk) disable iff (!rstN)
    (recWr && !clr && !full) |=> $stable(headQ)); // R1

  AST_POS_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    posQ <= countQ); // R6

  AST_CLEAR_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    clr |=> (countQ == '0 && !stopQ && !bestViewQ)); // R3

  AST_ENTER_OLDEST: assert property (@(posedge clk) disable iff (!rstN)
    (enterRecall && !clr) |=> (posQ == '0 && !bestViewQ)); // R5

endmodule

// File: rtl/recall_datapath.sv
module recall_datapath
  import recall_pkg::*;
#(
  parameter int DEPTH  = 10,
  parameter int NUM_W  = 7,
  parameter int TIME_W = 22,
  parameter int SLOT_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       strobes,
  input  logic [SLOT_W-1:0] wrSlot,
  input  logic [SLOT_W-1:0] viewSlot,
  input  recKind_t          kind,
  input  logic [NUM_W-1:0]  recNum,
  input  logic [TIME_W-1:0] recInterval,
  input  logic [TIME_W-1:0] recTotal,
  input  logic [TIME_W-1:0] stopInterval,
  input  logic [TIME_W-1:0] stopTotal,
  output logic              bestAvail,
  output logic              outValid,
  output logic [NUM_W-1:0]  outNum,
  output logic [TIME_W-1:0] outInterval,
  output logic [TIME_W-1:0] outTotal,
  output logic              outIsStop,
  output logic              outIsBest
);

  localparam logic [NUM_W-1:0] DASH_NUM = '1;

  logic [NUM_W-1:0]  slotNum [DEPTH];
  logic [TIME_W-1:0] slotInt [DEPTH];
  logic [TIME_W-1:0] slotTot [DEPTH];

  logic              bestValidQ;
  logic              bestInBufQ;
  logic [SLOT_W-1:0] bestSlotQ;
  logic [NUM_W-1:0]  bestNumQ;
  logic [TIME_W-1:0] bestIntQ;
  logic [TIME_W-1:0] bestTotQ;
  logic [TIME_W-1:0] stopIntQ;
  logic [TIME_W-1:0] stopTotQ;
  logic [TIME_W-1:0] lastTotQ;
  logic              newBest;

  // one register set per slot
  for (genvar s = 0; s < DEPTH; s++) begin : gSlot
    always_ff @(posedge clk) begin
      if (!rstN) begin
        slotNum[s] <= '0;
        slotInt[s] <= '0;
        slotTot[s] <= '0;
      end else if (strobes.wrRec && wrSlot == SLOT_W'(s)) begin
        slotNum[s] <= recNum;
        slotInt[s] <= recInterval;
        slotTot[s] <= recTotal;
      end
    end
  end

  assign newBest = strobes.wrRec && (kind == KIND_LAP) &&
                   (!bestValidQ || recInterval < bestIntQ);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bestValidQ <= 1'b0;
      bestInBufQ <= 1'b0;
      bestSlotQ  <= '0;
      bestNumQ   <= '0;
      bestIntQ   <= '0;
      bestTotQ   <= '0;
      stopIntQ   <= '0;
      stopTotQ   <= '0;
      lastTotQ   <= '0;
    end else if (strobes.clr) begin
      bestValidQ <= 1'b0;
      bestInBufQ <= 1'b0;
      lastTotQ   <= '0;
    end else begin
      if (newBest) begin
        bestValidQ <= 1'b1;
        bestInBufQ <= 1'b1;
        bestSlotQ  <= wrSlot;
        bestNumQ   <= recNum;
        bestIntQ   <= recInterval;
        bestTotQ   <= recTotal;
      end else if (strobes.evict && wrSlot == bestSlotQ) begin
        bestInBufQ <= 1'b0;
      end
      if (strobes.wrRec) lastTotQ <= recTotal;
      if (strobes.wrStop) begin
        stopIntQ <= stopInterval;
        stopTotQ <= stopTotal;
        lastTotQ <= stopTotal;
      end
    end
  end

  assign bestAvail = bestValidQ;

  always_comb begin
    outValid    = strobes.viewValid;
    outNum      = '0;
    outInterval = '0;
    outTotal    = '0;
    outIsStop   = 1'b0;
    outIsBest   = 1'b0;
    if (strobes.viewValid) begin
      if (strobes.viewBest) begin
        outNum      = bestNumQ;
        outInterval = bestIntQ;
        outTotal    = bestTotQ;
        outIsBest   = 1'b1;
      end else if (strobes.viewStop) begin
        outNum      = DASH_NUM;
        outInterval = stopIntQ;
        outTotal    = stopTotQ;
        outIsStop   = 1'b1;
      end else begin
        outNum      = slotNum[viewSlot];
        outInterval = slotInt[viewSlot];
        outTotal    = (kind == KIND_SPLIT) ? lastTotQ : slotTot[viewSlot];
        outIsBest   = bestValidQ && bestInBufQ && (viewSlot == bestSlotQ);
      end
    end
  end

  AST_BEST_NEVER_SLOWER: assert property (@(posedge clk) disable iff (!rstN)
    (bestValidQ && !strobes.clr) |=> (bestValidQ && bestIntQ <= $past(bestIntQ))); // R8

  AST_SPLIT_NO_BEST: assert property (@(posedge clk) disable iff (!rstN)
    (kind == KIND_SPLIT) |-> !bestValidQ); // R8

  AST_EMPTY_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> (!outIsBest && !outIsStop && outNum == '0)); // R11

endmodule

// File: rtl/recall_memory.sv
module recall_memory
  import recall_pkg::*;
#(
  parameter int DEPTH  = 10,
  parameter int NUM_W  = 7,
  parameter int TIME_W = 22
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              recWr,
  input  logic [NUM_W-1:0]  recNum,
  input  logic [TIME_W-1:0] recInterval,
  input  logic [TIME_W-1:0] recTotal,
  input  logic              stopWr,
  input  logic [TIME_W-1:0] stopInterval,
  input  logic [TIME_W-1:0] stopTotal,
  input  logic              clearAll,
  input  logic              modeTag,
  input  logic              btnNext,
  input  logic              btnPrev,
  input  logic              btnBest,
  input  logic              enterRecall,
  output logic              outValid,
  output logic [NUM_W-1:0]  outNum,
  output logic [TIME_W-1:0] outInterval,
  output logic [TIME_W-1:0] outTotal,
  output logic              outIsStop,
  output logic              outIsBest,
  output logic              outKind
);

  localparam int SLOT_W = $clog2(DEPTH);

  ctlStrobes_t       strobes;
  logic [SLOT_W-1:0] wrSlot;
  logic [SLOT_W-1:0] viewSlot;
  recKind_t          kind;
  logic              bestAvail;

  recall_control #(.DEPTH(DEPTH), .SLOT_W(SLOT_W)) u_control (
    .clk        (clk),
    .rstN       (rstN),
    .recWr      (recWr),
    .stopWr     (stopWr),
    .clearAll   (clearAll),
    .modeTag    (modeTag),
    .btnNext    (btnNext),
    .btnPrev    (btnPrev),
    .btnBest    (btnBest),
    .enterRecall(enterRecall),
    .bestAvail  (bestAvail),
    .strobes    (strobes),
    .wrSlot     (wrSlot),
    .viewSlot   (viewSlot),
    .kind       (kind)
  );

  recall_datapath #(.DEPTH(DEPTH), .NUM_W(NUM_W), .TIME_W(TIME_W),
                    .SLOT_W(SLOT_W)) u_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .wrSlot      (wrSlot),
    .viewSlot    (viewSlot),
    .kind        (kind),
    .recNum      (recNum),
    .recInterval (recInterval),
    .recTotal    (recTotal),
    .stopInterval(stopInterval),
    .stopTotal   (stopTotal),
    .bestAvail   (bestAvail),
    .outValid    (outValid),
    .outNum      (outNum),
    .outInterval (outInterval),
    .outTotal    (outTotal),
    .outIsStop   (outIsStop),
    .outIsBest   (outIsBest)
  );

  assign outKind = logic'(kind);

endmodule

// File: tb/recall_memory_bench.sv
module recall_memory_bench;

  localparam int DEPTH  = 10;
  localparam int NUM_W  = 7;
  localparam int TIME_W = 22;
  localparam int DASH   = (1 << NUM_W) - 1;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              recWr = 1'b0;
  logic [NUM_W-1:0]  recNum = '0;
  logic [TIME_W-1:0] recInterval = '0;
  logic [TIME_W-1:0] recTotal = '0;
  logic              stopWr = 1'b0;
  logic [TIME_W-1:0] stopInterval = '0;
  logic [TIME_W-1:0] stopTotal = '0;
  logic              clearAll = 1'b0;
  logic              modeTag = 1'b0;
  logic              btnNext = 1'b0;
  logic              btnPrev = 1'b0;
  logic              btnBest = 1'b0;
  logic              enterRecall = 1'b0;
  logic              outValid;
  logic [NUM_W-1:0]  outNum;
  logic [TIME_W-1:0] outInterval;
  logic [TIME_W-1:0] outTotal;
  logic              outIsStop;
  logic              outIsBest;
  logic              outKind;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  recall_memory #(.DEPTH(DEPTH), .NUM_W(NUM_W), .TIME_W(TIME_W)) u_recall_memory (
    .clk, .rstN, .recWr, .recNum, .recInterval, .recTotal, .stopWr,
    .stopInterval, .stopTotal, .clearAll, .modeTag, .btnNext, .btnPrev,
    .btnBest, .enterRecall, .outValid, .outNum, .outInterval, .outTotal,
    .outIsStop, .outIsBest, .outKind
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000 && !done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer than 20000", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic writeRec(input int n, input int iv, input int tot);
    tick();
    recWr = 1'b1; recNum = NUM_W'(n); recInterval = TIME_W'(iv); recTotal = TIME_W'(tot);
    tick();
    recWr = 1'b0;
  endtask

  task automatic writeStop(input int iv, input int tot);
    tick();
    stopWr = 1'b1; stopInterval = TIME_W'(iv); stopTotal = TIME_W'(tot);
    tick();
    stopWr = 1'b0;
  endtask

  task automatic doClear();
    tick(); clearAll = 1'b1; tick(); clearAll = 1'b0;
  endtask

  task automatic doEnter();
    tick(); enterRecall = 1'b1; tick(); enterRecall = 1'b0;
  endtask

  task automatic pressNext();
    tick(); btnNext = 1'b1; tick(); btnNext = 1'b0;
  endtask

  task automatic pressPrev();
    tick(); btnPrev = 1'b1; tick(); btnPrev = 1'b0;
  endtask

  task automatic pressBoth();
    tick(); btnNext = 1'b1; btnPrev = 1'b1; tick(); btnNext = 1'b0; btnPrev = 1'b0;
  endtask

  task automatic holdBest(input logic v);
    tick(); btnBest = v; tick();
  endtask

  task automatic setMode(input logic v);
    tick(); modeTag = v; tick();
  endtask

  task automatic testReset();
    check("R11 reset valid", int'(outValid), 0);
    check("R2 reset kind", int'(outKind), 0);
    check("R11 reset num", int'(outNum), 0);
  endtask

  task automatic testFillWrap();
    doClear();
    for (int k = 0; k < 12; k++) begin
      int n;
      int iv;
      n  = (k == 11) ? 5 : k + 5;
      iv = (k == 0) ? 10 : ((k == 11) ? 200 : 100 + k);
      writeRec(n, iv, 1000 * (k + 1));
    end
    doEnter();
    check("R1 oldest kept num", int'(outNum), 7);
    check("R1 oldest kept interval", int'(outInterval), 102);
    check("R10 lap cumulative", int'(outTotal), 3000);
    check("R9 oldest not best", int'(outIsBest), 0);
    for (int i = 0; i < 9; i++) pressNext();
    check("R1 newest num", int'(outNum), 5);
    check("R9 reused number not best", int'(outIsBest), 0);
    check("R9 newest interval", int'(outInterval), 200);
    pressNext();
    check("R6 saturate at newest", int'(outInterval), 200);
    holdBest(1'b1);
    check("R9 evicted best interval", int'(outInterval), 10);
    check("R9 evicted best total", int'(outTotal), 1000);
    check("R7 best flag in view", int'(outIsBest), 1);
    holdBest(1'b0);
    check("R7 restore after release", int'(outInterval), 200);
  endtask

  task automatic testTies();
    doClear();
    writeRec(1, 50, 50);
    writeRec(2, 40, 90);
    writeRec(3, 40, 130);
    doEnter();
    check("R8 slower not best", int'(outIsBest), 0);
    pressNext();
    check("R8 first fastest is best", int'(outIsBest), 1);
    pressNext();
    check("R8 tie keeps earlier", int'(outIsBest), 0);
  endtask

  task automatic testBestHold();
    doClear();
    writeRec(1, 30, 30);
    writeRec(2, 20, 50);
    writeRec(3, 40, 90);
    doEnter();
    holdBest(1'b1);
    check("R7 peek shows best num", int'(outNum), 2);
    check("R7 peek shows best total", int'(outTotal), 50);
    pressNext();
    check("R7 nav during hold restores", int'(outNum), 1);
    tick();
    check("R7 no reentry while held", int'(outNum), 1);
    holdBest(1'b0);
    holdBest(1'b1);
    check("R7 reentry after release", int'(outNum), 2);
    doEnter();
    check("R5 enter ends best view", int'(outIsBest), 0);
    holdBest(1'b0);
    check("R7 release restores", int'(outNum), 1);
  endtask

  task automatic testNav();
    pressPrev();
    check("R6 saturate at oldest", int'(outNum), 1);
    pressNext();
    check("R6 next steps", int'(outNum), 2);
    pressBoth();
    check("R6 both ignored", int'(outNum), 2);
    pressNext();
    pressNext();
    check("R6 saturate at last", int'(outNum), 3);
    pressPrev();
    check("R6 prev steps", int'(outNum), 2);
    doEnter();
    check("R5 enter to oldest", int'(outNum), 1);
  endtask

  task automatic testStop();
    doClear();
    writeRec(1, 10, 10);
    writeStop(5, 15);
    doEnter();
    pressNext();
    check("R4 stop flag", int'(outIsStop), 1);
    check("R4 stop dashes", int'(outNum), DASH);
    check("R4 stop interval", int'(outInterval), 5);
    check("R4 stop total", int'(outTotal), 15);
    pressNext();
    check("R6 saturate at stop", int'(outIsStop), 1);
    writeRec(2, 20, 30);
    check("R4 record removes stop", int'(outIsStop), 0);
    check("R4 new record at position", int'(outNum), 2);
    writeStop(7, 37);
    pressNext();
    check("R4 stop replaced", int'(outInterval), 7);
  endtask

  task automatic testSplit();
    setMode(1'b1);
    check("R2 toggle clears", int'(outValid), 0);
    check("R2 kind split", int'(outKind), 1);
    writeRec(1, 30, 30);
    writeRec(2, 70, 70);
    writeStop(90, 90);
    doEnter();
    check("R10 split final total", int'(outTotal), 90);
    check("R8 split no best", int'(outIsBest), 0);
    pressNext();
    check("R10 split second total", int'(outTotal), 90);
    holdBest(1'b1);
    check("R8 split best ignored", int'(outNum), 2);
    holdBest(1'b0);
  endtask

  task automatic testClear();
    doClear();
    check("R3 clear empties", int'(outValid), 0);
    pressNext();
    check("R11 nav on empty", int'(outValid), 0);
    writeRec(4, 8, 8);
    check("R3 refill valid", int'(outValid), 1);
    check("R3 refill num", int'(outNum), 4);
    setMode(1'b0);
    check("R2 toggle back clears", int'(outValid), 0);
    check("R2 kind lap", int'(outKind), 0);
  endtask

  initial begin
    repeat (3) tick();
    rstN = 1'b1;
    tick();
    testReset();
    testFillWrap();
    testTies();
    testBestHold();
    testNav();
    testStop();
    testSplit();
    testClear();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule